// File: doc/BRIEF.md
# Inter-port mailbox interrupt unit

This block lets two processors that share a dual-ported memory send short messages to each other without touching the shared array. Each port owns a small set of 16-bit mailbox words. The owner can write and read back its own words, and the peer port can only read them. When the owner writes the upper byte of one of its words, an interrupt is raised toward the peer for that mailbox. The peer acknowledges it by reading the upper byte of the same word. Reads never alter what is stored.

Each port also has three control words in its mailbox space. A mask word holds one bit per incoming source, and a set bit masks that source. A cause word records only those events that arrived while their source was unmasked. A status word shows every pending incoming event, masked or not. The port's interrupt line is high while any pending source is unmasked. Both ports are synchronous to one clock and use byte-lane enables. The mailbox space is reached only when the mailbox-select input is low and the chip enable is high, so mailbox accesses never collide with array accesses.

Top module: `mbox_irq_unit`

## Requirements
- R1: After reset, all mailbox words, masks, pending bits and cause bits are zero, both interrupt outputs are low and both read-data outputs are zero.
- R2: A port performs an access only in a cycle where its `sel_n` is 0 and its `ce` is 1. In any other cycle the access has no effect on any state, and the port's read data in the following cycle is zero.
- R3: At offset i (0..3), a port reads and writes its own mailbox i. Write-enable lane `be[0]` updates bits 7:0 and `be[1]` updates bits 15:8; a lane whose enable is clear keeps its old byte.
- R4: At offset 4+i, a port reads mailbox i of the peer port. A write at offset 4+i changes nothing.
- R5: A write to a port's own mailbox i with `be[1]` set marks source i pending at the peer. A write with only `be[0]` set marks nothing pending.
- R6: A read at offset 4+i with `be[1]` set clears the reader's pending source i. A read with only `be[0]` set clears nothing. No read changes any mailbox word.
- R7: Offset 8 is the mask word. Bits 3:0 are written when `be[0]` is set and always read back; bit i = 1 masks source i.
- R8: Offset 10 is the status word. Bits 3:0 show every pending source, masked or not.
- R9: Offset 9 is the cause word. Bit i is set when source i becomes pending while its mask bit is 0, is left unchanged by an event on a masked source, and is cleared by the same read that clears pending bit i.
- R10: A port's `irq` is high exactly when some pending source of that port is unmasked. It changes in the cycle after the write, clearing read or mask write that causes the change.
- R11: If a set and a clear of the same source happen in the same cycle, the source ends up pending.
- R12: Read data appears in the cycle after the read access, and read returns the full 16-bit word whatever the lane enables are. Offsets 11 to 15 read as zero. Writes to offsets 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sel_n | input | 1 | Port A mailbox select, active low |
| a_ce | input | 1 | Port A chip enable, active high |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_be | input | 2 | Port A byte-lane enables |
| a_addr | input | 4 | Port A word offset in the mailbox space |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, one cycle after the access |
| a_irq | output | 1 | Port A interrupt, active high |
| b_sel_n | input | 1 | Port B mailbox select, active low |
| b_ce | input | 1 | Port B chip enable, active high |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_be | input | 2 | Port B byte-lane enables |
| b_addr | input | 4 | Port B word offset in the mailbox space |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, one cycle after the access |
| b_irq | output | 1 | Port B interrupt, active high |

## Verification
The bench sweeps every mailbox, every lane combination and all sixteen mask values in both directions, and predicts each read word and interrupt level from an arithmetic model. A design that raised an interrupt on a lower-byte-only write, or cleared one on a lower-byte-only read, would show a wrong `irq` level right after that access. A design that let masked events into the cause word, or hid masked events from the status word, would return wrong words for those offsets during the mask sweep. A design where the clear wins over a set of the same source in the same cycle, or where a read of the peer's word or a write to a read-only offset alters state, would return wrong data on a later read-back.

// File: rtl/mbox_pkg.sv
// Package: shared types for the inter-port mailbox unit.
// Assumes nothing beyond the user modules importing it.
package mbox_pkg;

    // Kind of word addressed inside one port's mailbox space.
    typedef enum logic [2:0] {
        RG_NONE   = 3'd0,
        RG_OWN    = 3'd1,
        RG_PEER   = 3'd2,
        RG_MASK   = 3'd3,
        RG_CAUSE  = 3'd4,
        RG_STATUS = 3'd5
    } region_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/mbox_decode.sv
// Module: mbox_decode
// Turns one port's bus signals into per-mailbox strobes and a region code.
// Assumes NUM_MBOX is a power of two (>= 2). The space is laid out as own
// words, then peer words, then mask, cause and status.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 4,
    parameter int ADDR_W   = 4,
    parameter int BE_W     = 2,
    parameter int IDX_W    = 2
) (
    input  logic                           sel_n,
    input  logic                           ce,
    input  logic                           we,
    input  logic [BE_W-1:0]                be,
    input  logic [ADDR_W-1:0]              addr,
    output region_e                        region,
    output logic [IDX_W-1:0]               idx,
    output logic                           rd_acc,
    output logic [NUM_MBOX-1:0][BE_W-1:0]  own_lane_wr,
    output logic [NUM_MBOX-1:0]            peer_rd_hi,
    output logic                           mask_wr
);

    localparam int unsigned OFF_PEER   = NUM_MBOX;
    localparam int unsigned OFF_MASK   = 2 * NUM_MBOX;
    localparam int unsigned OFF_CAUSE  = OFF_MASK + 1;
    localparam int unsigned OFF_STATUS = OFF_MASK + 2;

    logic acc;
    logic wr_acc;

    assign acc    = !sel_n && ce;
    assign wr_acc = acc && we;
    assign rd_acc = acc && !we;
    assign idx    = addr[IDX_W-1:0];

    // Classify the offset into a region of the mailbox space.
    always_comb begin
        int unsigned a;
        a = 32'(addr);
        if (a < OFF_PEER)         region = RG_OWN;
        else if (a < OFF_MASK)    region = RG_PEER;
        else if (a == OFF_MASK)   region = RG_MASK;
        else if (a == OFF_CAUSE)  region = RG_CAUSE;
        else if (a == OFF_STATUS) region = RG_STATUS;
        else                      region = RG_NONE;
    end

    assign mask_wr = wr_acc && (region == RG_MASK) && be[0];

    // One set of strobes per mailbox slot.
    for (genvar n = 0; n < NUM_MBOX; n++) begin : g_strobe
        assign own_lane_wr[n] = (wr_acc && region == RG_OWN && idx == IDX_W'(n))
                                ? be : '0;
        assign peer_rd_hi[n]  = rd_acc && region == RG_PEER &&
                                idx == IDX_W'(n) && be[BE_W-1];
    end

endmodule

// File: rtl/mbox_store.sv
// Module: mbox_store
// Holds one port's mailbox words, written per byte lane by the owner only.
// Assumes DATA_W is a multiple of 8. Reads happen outside and never touch it.
module mbox_store
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 4,
    parameter int DATA_W   = 16,
    parameter int BE_W     = DATA_W / BYTE_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_MBOX-1:0][BE_W-1:0]   lane_wr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_MBOX-1:0][DATA_W-1:0] words
);

    logic [BYTE_W-1:0] byte_q [NUM_MBOX][BE_W];
    logic [NUM_MBOX-1:0] word_hit;

    for (genvar n = 0; n < NUM_MBOX; n++) begin : g_word
        assign word_hit[n] = |lane_wr[n];
        for (genvar b = 0; b < BE_W; b++) begin : g_lane
            // Store one byte of one mailbox when its lane strobe is set.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q[n][b] <= '0;
                else if (lane_wr[n][b])
                    byte_q[n][b] <= wdata[b*BYTE_W +: BYTE_W];
            end
            assign words[n][b*BYTE_W +: BYTE_W] = byte_q[n][b];
        end
    end

    // R3: the decoder addresses at most one mailbox per cycle.
    assert_single_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word_hit));

    // R6: without a write strobe the stored words stay as they are.
    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|word_hit) |=> $stable(words));

endmodule

// File: rtl/mbox_irq_ctrl.sv
// Module: mbox_irq_ctrl
// Keeps the mask, the pending (status) bits and the cause bits of one
// receiving port, and drives that port's interrupt line.
// Assumes the set and clear vectors are single-cycle strobes.
module mbox_irq_ctrl #(
    parameter int NUM_MBOX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MBOX-1:0] set,
    input  logic [NUM_MBOX-1:0] clr,
    input  logic                mask_wr,
    input  logic [NUM_MBOX-1:0] mask_wdata,
    output logic [NUM_MBOX-1:0] mask,
    output logic [NUM_MBOX-1:0] cause,
    output logic [NUM_MBOX-1:0] status,
    output logic                irq
);

    logic [NUM_MBOX-1:0] pend_q;

    // Mask register, written by the receiving port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (mask_wr)
            mask <= mask_wdata;
    end

    // Pending bits: a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr) | set;
    end

    // Cause bits: only events that arrive unmasked are recorded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause <= '0;
        else
            cause <= (cause & ~clr) | (set & ~mask);
    end

    assign status = pend_q;
    assign irq    = |(pend_q & ~mask);

    // R11: every source set in a cycle is pending in the next one.
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        |set |=> ((pend_q & $past(set)) == $past(set)));

    // R6: a clear without a competing set removes the pending bit.
    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr & ~set) |=> ((pend_q & $past(clr & ~set)) == '0));

    // R9: an event on a masked source leaves a clear cause bit clear.
    assert_masked_no_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        |(set & mask & ~cause) |=> ((cause & $past(set & mask & ~cause)) == '0));

    // R9: a cause bit is never set without its source pending.
    assert_cause_in_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cause & ~pend_q) == '0);

    // R10: the interrupt only rises after an event or a mask change.
    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|set) || $past(mask_wr)));

endmodule

// File: rtl/mbox_rd_port.sv
// Module: mbox_rd_port
// Registered read path of one port: selects the addressed word and returns
// it one cycle later, or zero when there was no read.
// Assumes the region code comes from mbox_decode of the same port.
module mbox_rd_port
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 4,
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_acc,
    input  region_e                         region,
    input  logic [IDX_W-1:0]                idx,
    input  logic [NUM_MBOX-1:0][DATA_W-1:0] own_words,
    input  logic [NUM_MBOX-1:0][DATA_W-1:0] peer_words,
    input  logic [NUM_MBOX-1:0]             mask,
    input  logic [NUM_MBOX-1:0]             cause,
    input  logic [NUM_MBOX-1:0]             status,
    output logic [DATA_W-1:0]               rdata
);

    logic [DATA_W-1:0] rd_sel;

    // Pick the word for the addressed region.
    always_comb begin
        unique case (region)
            RG_OWN:    rd_sel = own_words[idx];
            RG_PEER:   rd_sel = peer_words[idx];
            RG_MASK:   rd_sel = DATA_W'(mask);
            RG_CAUSE:  rd_sel = DATA_W'(cause);
            RG_STATUS: rd_sel = DATA_W'(status);
            default:   rd_sel = '0;
        endcase
    end

    // Register the read word; zero when the port did not read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_acc ? rd_sel : '0;
    end

    // R2: a cycle without a read access returns zero next cycle.
    assert_idle_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> (rdata == '0));

endmodule

// File: rtl/mbox_irq_unit.sv
// Module: mbox_irq_unit
// Two-port mailbox with per-mailbox interrupts. Each port owns NUM_MBOX
// words; a write of a word's upper byte interrupts the peer, and the peer
// clears it by reading that upper byte.
// Assumes one shared clock for both ports and NUM_MBOX a power of two <= 8.
module mbox_irq_unit
    import mbox_pkg::*;
#(
    parameter  int NUM_MBOX = 4,
    parameter  int DATA_W   = 16,
    localparam int ADDR_W   = $clog2(NUM_MBOX) + 2,
    localparam int BE_W     = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_ce,
    input  logic              a_we,
    input  logic [BE_W-1:0]   a_be,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    input  logic              b_sel_n,
    input  logic              b_ce,
    input  logic              b_we,
    input  logic [BE_W-1:0]   b_be,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq
);

    localparam int NPORT = 2;
    localparam int IDX_W = $clog2(NUM_MBOX);

    // Port signals gathered into arrays so both ports share one generate body.
    logic                            sel_n_v [NPORT];
    logic                            ce_v    [NPORT];
    logic                            we_v    [NPORT];
    logic [BE_W-1:0]                 be_v    [NPORT];
    logic [ADDR_W-1:0]               addr_v  [NPORT];
    logic [DATA_W-1:0]               wdata_v [NPORT];
    logic [DATA_W-1:0]               rdata_v [NPORT];
    logic                            irq_v   [NPORT];

    region_e                         region_v [NPORT];
    logic [IDX_W-1:0]                idx_v    [NPORT];
    logic                            rd_acc_v [NPORT];
    logic [NUM_MBOX-1:0][BE_W-1:0]   lane_v   [NPORT];
    logic [NUM_MBOX-1:0]             hi_wr_v  [NPORT];
    logic [NUM_MBOX-1:0]             clr_v    [NPORT];
    logic                            mask_wr_v[NPORT];
    logic [NUM_MBOX-1:0][DATA_W-1:0] words_v  [NPORT];
    logic [NUM_MBOX-1:0]             mask_v   [NPORT];
    logic [NUM_MBOX-1:0]             cause_v  [NPORT];
    logic [NUM_MBOX-1:0]             status_v [NPORT];

    assign sel_n_v[0] = a_sel_n;  assign sel_n_v[1] = b_sel_n;
    assign ce_v[0]    = a_ce;     assign ce_v[1]    = b_ce;
    assign we_v[0]    = a_we;     assign we_v[1]    = b_we;
    assign be_v[0]    = a_be;     assign be_v[1]    = b_be;
    assign addr_v[0]  = a_addr;   assign addr_v[1]  = b_addr;
    assign wdata_v[0] = a_wdata;  assign wdata_v[1] = b_wdata;
    assign a_rdata    = rdata_v[0];
    assign b_rdata    = rdata_v[1];
    assign a_irq      = irq_v[0];
    assign b_irq      = irq_v[1];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int PEER = NPORT - 1 - p;

        mbox_decode #(
            .NUM_MBOX (NUM_MBOX),
            .ADDR_W   (ADDR_W),
            .BE_W     (BE_W),
            .IDX_W    (IDX_W)
        ) u_dec (
            .sel_n       (sel_n_v[p]),
            .ce          (ce_v[p]),
            .we          (we_v[p]),
            .be          (be_v[p]),
            .addr        (addr_v[p]),
            .region      (region_v[p]),
            .idx         (idx_v[p]),
            .rd_acc      (rd_acc_v[p]),
            .own_lane_wr (lane_v[p]),
            .peer_rd_hi  (clr_v[p]),
            .mask_wr     (mask_wr_v[p])
        );

        // Upper-lane write strobes of this port's own words.
        for (genvar n = 0; n < NUM_MBOX; n++) begin : g_hi
            assign hi_wr_v[p][n] = lane_v[p][n][BE_W-1];
        end

        mbox_store #(
            .NUM_MBOX (NUM_MBOX),
            .DATA_W   (DATA_W),
            .BE_W     (BE_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .lane_wr (lane_v[p]),
            .wdata   (wdata_v[p]),
            .words   (words_v[p])
        );

        // Events toward this port come from the peer's upper-lane writes.
        mbox_irq_ctrl #(
            .NUM_MBOX (NUM_MBOX)
        ) u_irq (
            .clk        (clk),
            .rst_n      (rst_n),
            .set        (hi_wr_v[PEER]),
            .clr        (clr_v[p]),
            .mask_wr    (mask_wr_v[p]),
            .mask_wdata (wdata_v[p][NUM_MBOX-1:0]),
            .mask       (mask_v[p]),
            .cause      (cause_v[p]),
            .status     (status_v[p]),
            .irq        (irq_v[p])
        );

        mbox_rd_port #(
            .NUM_MBOX (NUM_MBOX),
            .DATA_W   (DATA_W),
            .IDX_W    (IDX_W)
        ) u_rd (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_acc     (rd_acc_v[p]),
            .region     (region_v[p]),
            .idx        (idx_v[p]),
            .own_words  (words_v[p]),
            .peer_words (words_v[PEER]),
            .mask       (mask_v[p]),
            .cause      (cause_v[p]),
            .status     (status_v[p]),
            .rdata      (rdata_v[p])
        );
    end

endmodule

// File: tb/mbox_irq_unit_test.sv
// Bench for mbox_irq_unit: sweeps mailboxes, lanes and masks on both ports
// against an arithmetic model and counts its own checks.
module mbox_irq_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;

    logic        q_sel_n [2];
    logic        q_ce    [2];
    logic        q_we    [2];
    logic [1:0]  q_be    [2];
    logic [3:0]  q_ad    [2];
    logic [15:0] q_wd    [2];
    logic [15:0] rd_o    [2];
    logic        irq_o   [2];

    logic [15:0] m_mb    [2][4];
    logic [3:0]  m_pend  [2];
    logic [3:0]  m_cause [2];
    logic [3:0]  m_mask  [2];

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_irq_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_sel_n (q_sel_n[0]), .a_ce (q_ce[0]), .a_we (q_we[0]),
        .a_be    (q_be[0]),    .a_addr (q_ad[0]), .a_wdata (q_wd[0]),
        .a_rdata (rd_o[0]),    .a_irq (irq_o[0]),
        .b_sel_n (q_sel_n[1]), .b_ce (q_ce[1]), .b_we (q_we[1]),
        .b_be    (q_be[1]),    .b_addr (q_ad[1]), .b_wdata (q_wd[1]),
        .b_rdata (rd_o[1]),    .b_irq (irq_o[1])
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_all();
        for (int p = 0; p < 2; p++) begin
            q_sel_n[p] = 1'b1; q_ce[p] = 1'b0; q_we[p] = 1'b0;
            q_be[p] = 2'b00;   q_ad[p] = 4'd0; q_wd[p] = 16'h0;
        end
    endtask

    task automatic req(input int p, input logic we, input logic [1:0] be,
                       input logic [3:0] ad, input logic [15:0] wd);
        q_sel_n[p] = 1'b0; q_ce[p] = 1'b1; q_we[p] = we;
        q_be[p] = be;      q_ad[p] = ad;   q_wd[p] = wd;
    endtask

    function automatic logic [15:0] model_read(input int p, input logic [3:0] ad);
        if (ad < 4)        return m_mb[p][ad[1:0]];
        else if (ad < 8)   return m_mb[1-p][ad[1:0]];
        else if (ad == 8)  return {12'h0, m_mask[p]};
        else if (ad == 9)  return {12'h0, m_cause[p]};
        else if (ad == 10) return {12'h0, m_pend[p]};
        return 16'h0;
    endfunction

    // One clock with the queued requests; starts and ends at a falling edge.
    task automatic step(input string tag);
        logic [15:0] exp_rd [2];
        logic [3:0]  set_v  [2];
        logic [3:0]  clr_v  [2];
        logic [3:0]  new_mask [2];
        for (int p = 0; p < 2; p++) begin
            exp_rd[p] = (!q_sel_n[p] && q_ce[p] && !q_we[p]) ? model_read(p, q_ad[p]) : 16'h0;
            set_v[p] = 4'h0; clr_v[p] = 4'h0; new_mask[p] = m_mask[p];
        end
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            if (!q_sel_n[p] && q_ce[p]) begin
                if (q_we[p] && q_ad[p] < 4) begin
                    if (q_be[p][0]) m_mb[p][q_ad[p][1:0]][7:0]  = q_wd[p][7:0];
                    if (q_be[p][1]) m_mb[p][q_ad[p][1:0]][15:8] = q_wd[p][15:8];
                    if (q_be[p][1]) set_v[1-p][q_ad[p][1:0]] = 1'b1;
                end
                if (q_we[p] && q_ad[p] == 8 && q_be[p][0]) new_mask[p] = q_wd[p][3:0];
                if (!q_we[p] && q_ad[p] >= 4 && q_ad[p] < 8 && q_be[p][1])
                    clr_v[p][q_ad[p][1:0]] = 1'b1;
            end
        end
        for (int r = 0; r < 2; r++) begin
            m_cause[r] = (m_cause[r] & ~clr_v[r]) | (set_v[r] & ~m_mask[r]);
            m_pend[r]  = (m_pend[r] & ~clr_v[r]) | set_v[r];
            m_mask[r]  = new_mask[r];
        end
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            chk({tag, " rdata"}, rd_o[p], exp_rd[p]);
            chk({tag, " R10 irq"}, {15'h0, irq_o[p]}, {15'h0, |(m_pend[p] & ~m_mask[p])});
        end
        idle_all();
    endtask

    task automatic op(input string tag, input int p, input logic we, input logic [1:0] be,
                      input logic [3:0] ad, input logic [15:0] wd);
        req(p, we, be, ad, wd);
        step(tag);
    endtask

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        idle_all();
        for (int p = 0; p < 2; p++) begin
            m_pend[p] = 4'h0; m_cause[p] = 4'h0; m_mask[p] = 4'h0;
            for (int i = 0; i < 4; i++) m_mb[p][i] = 16'h0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs at reset.
        for (int p = 0; p < 2; p++) begin
            chk("R1 rdata", rd_o[p], 16'h0);
            chk("R1 irq", {15'h0, irq_o[p]}, 16'h0);
        end
        rst_n = 1'b1;

        // R1 / R12: every offset of both ports reads zero after reset.
        for (int ad = 0; ad < 16; ad++) begin
            req(0, 1'b0, 2'b11, 4'(ad), 16'h0);
            req(1, 1'b0, 2'b11, 4'(ad), 16'h0);
            step("R1");
        end

        // R2: deselected or disabled writes change nothing.
        req(0, 1'b1, 2'b11, 4'd0, 16'hDEAD); q_sel_n[0] = 1'b1; step("R2");
        req(0, 1'b1, 2'b11, 4'd1, 16'hBEEF); q_ce[0] = 1'b0;    step("R2");
        req(1, 1'b0, 2'b11, 4'd4, 16'h0);    q_ce[1] = 1'b0;    step("R2");
        op("R2", 0, 1'b0, 2'b11, 4'd0, 16'h0);
        op("R2", 0, 1'b0, 2'b11, 4'd1, 16'h0);

        // R3-R6: every mailbox, every lane pattern, both directions.
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 4; i++) begin
                for (int be = 1; be < 4; be++) begin
                    logic [15:0] d;
                    d = {4'(p + 5), 4'(i + 1), 4'(be + 8), 4'(i * 3 + be)};
                    op("R3 R5 write", p, 1'b1, 2'(be), 4'(i), d);
                    op("R3 readback", p, 1'b0, 2'b01, 4'(i), 16'h0);
                    op("R4 peer write ignored", 1 - p, 1'b1, 2'b11, 4'(4 + i), 16'h5A5A);
                    op("R6 low read keeps", 1 - p, 1'b0, 2'b01, 4'(4 + i), 16'h0);
                    op("R8 status", 1 - p, 1'b0, 2'b00, 4'd10, 16'h0);
                    op("R6 high read clears", 1 - p, 1'b0, 2'b10, 4'(4 + i), 16'h0);
                    op("R6 contents kept", 1 - p, 1'b0, 2'b11, 4'(4 + i), 16'h0);
                end
            end
        end

        // R7-R9: all mask values, both receiving ports.
        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 16; m++) begin
                op("R7 mask write", r, 1'b1, 2'b01, 4'd8, {12'hFFF, 4'(m)});
                op("R7 mask read", r, 1'b0, 2'b00, 4'd8, 16'h0);
                for (int i = 0; i < 4; i++)
                    op("R5 set", 1 - r, 1'b1, 2'b10, 4'(i), 16'(m * 256 + i));
                op("R8 status", r, 1'b0, 2'b00, 4'd10, 16'h0);
                op("R9 cause", r, 1'b0, 2'b00, 4'd9, 16'h0);
                for (int i = 0; i < 4; i++)
                    op("R6 clear", r, 1'b0, 2'b10, 4'(4 + i), 16'h0);
                op("R9 cause cleared", r, 1'b0, 2'b00, 4'd9, 16'h0);
            end
            op("R7 mask lane1 only", r, 1'b1, 2'b10, 4'd8, 16'h0000);
            op("R7 mask read", r, 1'b0, 2'b00, 4'd8, 16'h0);
            op("R7 unmask", r, 1'b1, 2'b01, 4'd8, 16'h0000);
        end

        // R9 / R10: event while masked, then unmask: irq rises, cause stays clear.
        op("R7 mask", 1, 1'b1, 2'b01, 4'd8, 16'h0001);
        op("R9 masked set", 0, 1'b1, 2'b10, 4'd0, 16'h7700);
        op("R10 unmask", 1, 1'b1, 2'b01, 4'd8, 16'h0000);
        op("R9 cause", 1, 1'b0, 2'b00, 4'd9, 16'h0);
        op("R8 status", 1, 1'b0, 2'b00, 4'd10, 16'h0);
        op("R6 clear", 1, 1'b0, 2'b10, 4'd4, 16'h0);

        // R11: set and clear of the same source in one cycle.
        for (int i = 0; i < 4; i++) begin
            op("R11 prime", 0, 1'b1, 2'b10, 4'(i), 16'h1100);
            req(0, 1'b1, 2'b10, 4'(i), 16'h2200);
            req(1, 1'b0, 2'b10, 4'(4 + i), 16'h0);
            step("R11 same cycle");
            op("R11 status", 1, 1'b0, 2'b00, 4'd10, 16'h0);
            op("R11 clear", 1, 1'b0, 2'b10, 4'(4 + i), 16'h0);
        end
        req(1, 1'b1, 2'b10, 4'd3, 16'h3300);
        req(0, 1'b0, 2'b10, 4'd7, 16'h0);
        step("R11 reverse");
        op("R11 status", 0, 1'b0, 2'b00, 4'd10, 16'h0);

        // R12: writes to read-only and unmapped offsets change nothing.
        for (int p = 0; p < 2; p++) begin
            for (int ad = 9; ad < 16; ad++)
                op("R12 ro write", p, 1'b1, 2'b11, 4'(ad), 16'hFFFF);
            for (int ad = 0; ad < 16; ad++)
                op("R12 read all", p, 1'b0, 2'b00, 4'(ad), 16'h0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule